// File: doc/BRIEF.md
# Two-Phase Sampled Input Glitch Filter

This block cleans the two counter inputs of a pulse or quadrature counter before the counter sees them. Both inputs arrive already synchronised to the sampling clock. Each phase has its own stability counter. An input change passes to the output only after the raw level has stayed at its new value for a programmable number of samples. That number is the length field plus a fixed offset of five. A pulse shorter than this never reaches the output.

A second stage is meant for quadrature encoders and works only when the source mode is the oversampled quadrature mode. It suppresses flutter on one phase: an edge that simply undoes the last edge accepted on the same phase is held back until the other phase moves. The counter logic, the input synchronisers and the mode register that drives the block all lie outside it.

When filtering is switched off, or the source mode does not sample the inputs, each input passes straight through with one register stage of delay.

Top module: `glf_top`

## Requirements
- R1: While `rst` is high at a clock edge, both `clean_a` and `clean_b` are 0 after that edge, and the stability history and the flutter history are cleared.
- R2: With the filter active, an output takes the raw level at the clock edge where the raw input has been sampled at that new level for `filt_len + 5` consecutive edges. A field of 0 gives 5 samples.
- R3: With the filter active, a raw pulse that lasts fewer than `filt_len + 5` samples leaves the output unchanged, and the stability count starts again from the next change.
- R4: The filter is active only when `filt_en` is 1 and `src_mode` is 2'b01 or 2'b10. In any other case the output equals the raw input sampled at the previous clock edge.
- R5: The `src_mode` encoding is 2'b00 externally clocked single input, 2'b01 oversampled single input, 2'b10 oversampled quadrature, 2'b11 externally clocked quadrature. Codes 2'b00 and 2'b11 never filter, even with `filt_en` at 1.
- R6: When `flut_en` is 1 and `src_mode` is 2'b10, an output edge on one phase is withheld if the most recent accepted edge was on that same phase. The withheld edge is applied at the clock edge after the other phase's edge is accepted, provided the raw level still differs.
- R7: With `flut_en` at 0, or with any `src_mode` other than 2'b10, successive edges on the same phase all pass.
- R8: The two phases are filtered independently: a long hold on one phase and a short pulse on the other give a change on the first phase only.
- R9: The largest field value, 255, needs 260 consecutive samples, and 259 are not enough.
- R10: When both phases' edges are accepted at the same clock edge, the flutter history is cleared, so the next edge on either phase passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_a | input | 1 | Phase A input, already synchronised |
| raw_b | input | 1 | Phase B input, already synchronised |
| filt_en | input | 1 | Enables the stability filter |
| filt_len | input | LEN_W (8) | Length field; required stable samples = value + 5 |
| flut_en | input | 1 | Enables flutter suppression (quadrature mode only) |
| src_mode | input | 2 | Counter source mode, encoded as in R5 |
| clean_a | output | 1 | Conditioned phase A |
| clean_b | output | 1 | Conditioned phase B |

## Verification
The filter is driven with pulses exactly one sample shorter than the required length and with holds of exactly the required length. This separates a correct threshold from an off-by-one, at the default length and at the largest field value. Bypass is driven with single-sample toggles under every mode code. A one-cycle pass-through is then told apart from a filter that is wrongly left active. The flutter stage is given a same-phase back-and-forth, an other-phase release and simultaneous edges. These show whether edges are blocked, released one cycle later, or let through from a cleared history. Seeded random toggling under changing configuration is compared with a bench model sample by sample.

// File: rtl/glf_pkg.sv
package glf_pkg;

    typedef enum logic [1:0] {
        SRC_EXT_SINGLE = 2'b00,
        SRC_OVS_SINGLE = 2'b01,
        SRC_OVS_QUAD   = 2'b10,
        SRC_EXT_QUAD   = 2'b11
    } src_mode_e;

    localparam int NUM_PH = 2;

    // Flutter history: which phase produced the last accepted edge.
    typedef struct packed {
        logic vld;
        logic ph;
    } edge_hist_t;

    function automatic logic mode_samples(src_mode_e m);
        return (m == SRC_OVS_SINGLE) || (m == SRC_OVS_QUAD);
    endfunction

    function automatic logic mode_is_quad_ovs(src_mode_e m);
        return m == SRC_OVS_QUAD;
    endfunction

endpackage

// File: rtl/glf_stab.sv
module glf_stab #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             active,
    input  logic [CNT_W-1:0] need,
    input  logic             accept,
    output logic             lvl,
    output logic             want
);
    logic [CNT_W-1:0] seen;
    logic             differs;

    always_comb begin
        differs = (raw != lvl);
        // seen counts earlier mismatched samples; this sample makes seen+1.
        want    = differs && (!active || (seen >= need - CNT_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl  <= 1'b0;
            seen <= '0;
        end else if (want && accept) begin
            lvl  <= raw;
            seen <= '0;
        end else if (!differs) begin
            seen <= '0;
        end else if (seen != '1) begin
            seen <= seen + CNT_W'(1);
        end
    end
endmodule

// File: rtl/glf_flutter.sv
module glf_flutter
    import glf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [NUM_PH-1:0] want,
    output logic [NUM_PH-1:0] accept
);
    edge_hist_t        hist;
    logic [NUM_PH-1:0] commit;

    always_comb begin
        for (int p = 0; p < NUM_PH; p++) begin
            accept[p] = !(enable && hist.vld && (hist.ph == 1'(p)));
        end
        commit = want & accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            case (commit)
                2'b11:   hist <= '0;
                2'b01:   hist <= '{vld: 1'b1, ph: 1'b0};
                2'b10:   hist <= '{vld: 1'b1, ph: 1'b1};
                default: hist <= hist;
            endcase
        end
    end
endmodule

// File: rtl/glf_top.sv
module glf_top
    import glf_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int OFFSET = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_a,
    input  logic             raw_b,
    input  logic             filt_en,
    input  logic [LEN_W-1:0] filt_len,
    input  logic             flut_en,
    input  logic [1:0]       src_mode,
    output logic             clean_a,
    output logic             clean_b
);
    localparam int MAX_NEED = (1 << LEN_W) - 1 + OFFSET;
    localparam int CNT_W    = $clog2(MAX_NEED + 1) + 1;

    src_mode_e         mode;
    logic              filt_on;
    logic              flut_on;
    logic [CNT_W-1:0]  need;
    logic [NUM_PH-1:0] raw_v, lvl_v, want_v, acc_v;

    always_comb begin
        mode    = src_mode_e'(src_mode);
        filt_on = filt_en && mode_samples(mode);
        flut_on = flut_en && mode_is_quad_ovs(mode);
        need    = CNT_W'(filt_len) + CNT_W'(OFFSET);
        raw_v   = {raw_b, raw_a};
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        glf_stab #(.CNT_W(CNT_W)) u_stab (
            .clk    (clk),
            .rst    (rst),
            .raw    (raw_v[p]),
            .active (filt_on),
            .need   (need),
            .accept (acc_v[p]),
            .lvl    (lvl_v[p]),
            .want   (want_v[p])
        );
    end

    glf_flutter u_flut (
        .clk    (clk),
        .rst    (rst),
        .enable (flut_on),
        .want   (want_v),
        .accept (acc_v)
    );

    assign clean_a = lvl_v[0];
    assign clean_b = lvl_v[1];
endmodule

// File: rtl/glf_chk.sv
module glf_chk #(
    parameter int LEN_W  = 8,
    parameter int OFFSET = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             raw_a,
    input logic             raw_b,
    input logic             filt_en,
    input logic [LEN_W-1:0] filt_len,
    input logic             flut_en,
    input logic [1:0]       src_mode,
    input logic             clean_a,
    input logic             clean_b
);
    logic       act, fl;
    int         need;
    int         run_a, run_b, run_a_now, run_b_now;
    logic       prev_raw_a, prev_raw_b;
    logic       prev_out_a, prev_out_b;
    logic       hv, hp, hv_now, hp_now;
    logic       ea, eb;

    always_comb begin
        act       = filt_en && (src_mode == 2'b01 || src_mode == 2'b10);
        fl        = flut_en && (src_mode == 2'b10);
        need      = int'(filt_len) + OFFSET;
        run_a_now = (raw_a == prev_raw_a) ? run_a + 1 : 1;
        run_b_now = (raw_b == prev_raw_b) ? run_b + 1 : 1;
        ea        = clean_a != prev_out_a;
        eb        = clean_b != prev_out_b;
        if (ea && eb)      begin hv_now = 1'b0; hp_now = 1'b0; end
        else if (ea)       begin hv_now = 1'b1; hp_now = 1'b0; end
        else if (eb)       begin hv_now = 1'b1; hp_now = 1'b1; end
        else               begin hv_now = hv;   hp_now = hp;   end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_a <= 0; run_b <= 0;
            prev_raw_a <= 1'b0; prev_raw_b <= 1'b0;
            prev_out_a <= 1'b0; prev_out_b <= 1'b0;
            hv <= 1'b0; hp <= 1'b0;
        end else begin
            run_a <= (run_a_now > 100000) ? 100000 : run_a_now;
            run_b <= (run_b_now > 100000) ? 100000 : run_b_now;
            prev_raw_a <= raw_a; prev_raw_b <= raw_b;
            prev_out_a <= clean_a; prev_out_b <= clean_b;
            hv <= hv_now; hp <= hp_now;
        end
    end

    // R1
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (clean_a == 1'b0 && clean_b == 1'b0));

    // R3: no output change before the required run length
    a_r3_no_early_a: assert property (@(posedge clk) disable iff (rst)
        (act && raw_a != clean_a && run_a_now < need) |=> $stable(clean_a));
    a_r3_no_early_b: assert property (@(posedge clk) disable iff (rst)
        (act && raw_b != clean_b && run_b_now < need) |=> $stable(clean_b));

    // R2: change is due once the run length is reached (flutter off)
    a_r2_change_due_a: assert property (@(posedge clk) disable iff (rst)
        (act && !fl && raw_a != clean_a && run_a_now >= need) |=> (clean_a == $past(raw_a)));

    // R4: bypass is a single register stage
    a_r4_bypass_a: assert property (@(posedge clk) disable iff (rst)
        (!act && !fl) |=> (clean_a == $past(raw_a) && clean_b == $past(raw_b)));

    // R6: same-phase edge after same-phase edge is withheld
    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        (fl && hv_now && !hp_now) |=> $stable(clean_a));
    a_r6_hold_b: assert property (@(posedge clk) disable iff (rst)
        (fl && hv_now && hp_now) |=> $stable(clean_b));
endmodule

bind glf_top glf_chk #(.LEN_W(LEN_W), .OFFSET(OFFSET)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .raw_a    (raw_a),
    .raw_b    (raw_b),
    .filt_en  (filt_en),
    .filt_len (filt_len),
    .flut_en  (flut_en),
    .src_mode (src_mode),
    .clean_a  (clean_a),
    .clean_b  (clean_b)
);

// File: tb/glf_top_tb.sv
`timescale 1ns/1ps
module glf_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw_a = 1'b0, raw_b = 1'b0;
    logic       filt_en = 1'b0, flut_en = 1'b0;
    logic [7:0] filt_len = 8'd0;
    logic [1:0] src_mode = 2'b00;
    logic       clean_a, clean_b;

    int checks = 0, failures = 0;
    bit done = 0;
    string cur_tag = "R1";

    // bench model state
    logic m_out [2];
    logic m_prev[2];
    int   m_run [2];
    logic m_hv, m_hp;

    always #2 clk = ~clk;

    glf_top u_dut (
        .clk(clk), .rst(rst), .raw_a(raw_a), .raw_b(raw_b),
        .filt_en(filt_en), .filt_len(filt_len), .flut_en(flut_en),
        .src_mode(src_mode), .clean_a(clean_a), .clean_b(clean_b)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    function automatic logic filt_active();
        return filt_en && (src_mode == 2'b01 || src_mode == 2'b10);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_out[i] = 1'b0; m_prev[i] = 1'b0; m_run[i] = 0;
        end
        m_hv = 1'b0; m_hp = 1'b0;
    endtask

    task automatic model_step(input logic a, input logic b);
        logic raw[2];
        logic want[2], com[2];
        int   need;
        logic fl;
        raw[0] = a; raw[1] = b;
        need = int'(filt_len) + 5;
        fl = flut_en && (src_mode == 2'b10);
        for (int i = 0; i < 2; i++) begin
            m_run[i] = (raw[i] == m_prev[i]) ? m_run[i] + 1 : 1;
            m_prev[i] = raw[i];
            want[i] = (raw[i] != m_out[i]) && (!filt_active() || m_run[i] >= need);
            com[i] = want[i] && !(fl && m_hv && (m_hp == (i == 1)));
        end
        if (com[0] && com[1]) m_hv = 1'b0;
        else if (com[0]) begin m_hv = 1'b1; m_hp = 1'b0; end
        else if (com[1]) begin m_hv = 1'b1; m_hp = 1'b1; end
        for (int i = 0; i < 2; i++) if (com[i]) m_out[i] = raw[i];
    endtask

    // drive inputs away from the edge, then compare after the edge
    task automatic step(input logic a, input logic b);
        raw_a = a; raw_b = b;
        @(posedge clk); #1;
        model_step(a, b);
        chk({cur_tag, " model a"}, clean_a, m_out[0]);
        chk({cur_tag, " model b"}, clean_b, m_out[1]);
    endtask

    task automatic hold(input logic a, input logic b, input int n);
        for (int k = 0; k < n; k++) step(a, b);
    endtask

    task automatic do_reset();
        rst = 1'b1; raw_a = 1'b0; raw_b = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        chk("R1 reset a", clean_a, 1'b0);
        chk("R1 reset b", clean_b, 1'b0);
        rst = 1'b0;
    endtask

    task automatic cfg(input logic fe, input logic [7:0] len, input logic fle, input logic [1:0] md);
        filt_en = fe; filt_len = len; flut_en = fle; src_mode = md;
    endtask

    initial begin
        void'($urandom(42));
        @(posedge clk); #1;
        do_reset();

        // R4 bypass with filter disabled
        cur_tag = "R4";
        cfg(0, 8'd3, 0, 2'b01);
        step(1, 0); chk("R4 pass one cycle a", clean_a, 1'b1);
        step(0, 1); chk("R4 pass a back", clean_a, 1'b0); chk("R4 pass b", clean_b, 1'b1);
        hold(0, 0, 2);

        // R5 non-sampled modes never filter
        cur_tag = "R5";
        cfg(1, 8'd3, 0, 2'b00);
        step(1, 0); chk("R5 mode00 no filter", clean_a, 1'b1);
        cfg(1, 8'd3, 0, 2'b11);
        step(0, 1); chk("R5 mode11 no filter a", clean_a, 1'b0);
        chk("R5 mode11 no filter b", clean_b, 1'b1);
        step(0, 0);

        // R2 default length 5
        cur_tag = "R2";
        cfg(1, 8'd0, 0, 2'b01);
        hold(0, 0, 2);
        hold(1, 0, 4); chk("R2 four samples not enough", clean_a, 1'b0);
        step(1, 0);    chk("R2 fifth sample flips", clean_a, 1'b1);

        // R3 short pulse then restart, length 7
        cur_tag = "R3";
        cfg(1, 8'd2, 0, 2'b10);
        hold(0, 0, 6); chk("R3 six-sample pulse rejected", clean_a, 1'b1);
        step(1, 0);
        hold(0, 0, 6); chk("R3 restart after return", clean_a, 1'b1);
        step(0, 0);    chk("R3 seventh sample flips", clean_a, 1'b0);

        // R8 independent phases
        cur_tag = "R8";
        cfg(1, 8'd1, 0, 2'b01);
        hold(1, 1, 3); hold(1, 0, 3);
        chk("R8 long hold a flips", clean_a, 1'b1);
        chk("R8 short pulse b rejected", clean_b, 1'b0);
        hold(0, 0, 6);

        // R9 largest field
        cur_tag = "R9";
        cfg(1, 8'd255, 0, 2'b01);
        hold(0, 1, 259); chk("R9 259 samples not enough", clean_b, 1'b0);
        step(0, 1);      chk("R9 260th sample flips", clean_b, 1'b1);

        // R10 simultaneous edges clear flutter history
        cur_tag = "R10";
        do_reset();
        cfg(0, 8'd0, 1, 2'b10);
        step(1, 1); chk("R10 both accepted a", clean_a, 1'b1); chk("R10 both accepted b", clean_b, 1'b1);
        step(0, 1); chk("R10 next edge passes", clean_a, 1'b0);

        // R6 flutter suppression
        cur_tag = "R6";
        step(1, 1); chk("R6 first a edge blocked", clean_a, 1'b0);
        step(1, 0); chk("R6 b edge accepted", clean_b, 1'b0);
        chk("R6 a still held", clean_a, 1'b0);
        step(1, 0); chk("R6 held a released", clean_a, 1'b1);
        step(0, 0); chk("R6 a undo blocked", clean_a, 1'b1);
        step(0, 1); chk("R6 b releases", clean_b, 1'b1);
        step(0, 1); chk("R6 a applied after b", clean_a, 1'b0);

        // R7 flutter inactive outside quad mode or when disabled
        cur_tag = "R7";
        cfg(0, 8'd0, 1, 2'b01);
        step(1, 1); step(0, 1); chk("R7 mode01 toggle passes", clean_a, 1'b0);
        cfg(0, 8'd0, 0, 2'b10);
        step(1, 1); step(0, 1); chk("R7 flutter off toggle passes", clean_a, 1'b0);

        // seeded random with model comparison
        cur_tag = "R2 R3 R6 random";
        for (int seg = 0; seg < 20; seg++) begin
            cfg(1'($urandom), 8'($urandom % 7), 1'($urandom), 2'($urandom));
            for (int k = 0; k < 200; k++) begin
                logic na, nb;
                na = (($urandom % 6) == 0) ? ~raw_a : raw_a;
                nb = (($urandom % 6) == 0) ? ~raw_b : raw_b;
                step(na, nb);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule